// File: doc/BRIEF.md
# MSI-X Vector Table and Pending-Bit Store

This block holds the per-vector message table and the pending-bit array of a message-signalled interrupt scheme. It has three ports. The host programs the table through a flat memory-mapped slave port using byte offsets. The application logic raises interrupt requests on a request port. The interrupt processor uses a lookup port that returns one vector's message address, data, mask and pending state, and it clears the pending bit once the message has gone out. Address decoding of the enclosing BAR, the capability structure in configuration space and packet building sit outside the block.

The table starts at offset 0 of the block's window. Each vector takes a 16-byte slot made of four 32-bit words. The pending array starts at the parameter `PBA_BASE`, and the host can read it in 32-bit or 64-bit units. Only application requests can set a pending bit, and only the interrupt processor can clear one. Host writes that land in the pending array are dropped. The vector count is a parameter from 1 to 2048. The block reports it as an encoded size field equal to the count minus one.

Top module: `msix_vector_store`

## Requirements
- R1: Vector n occupies byte offsets 16n to 16n+15. Word +0 is the low message address, +4 the high message address, +8 the message data and +12 the vector control. A 32-bit access (`host_qw`=0) uses `host_addr[3:2]` to pick the word. Reads return it in `host_rdata[31:0]` with bits 63:32 zero, and writes take `host_wdata[31:0]`.
- R2: A 64-bit table access (`host_qw`=1) ignores `host_addr[2:0]`. When `host_addr[3]`=0 it moves {high address, low address} as bits {63:32, 31:0}. When `host_addr[3]`=1 it moves {vector control, data}.
- R3: Only bit 0 of vector control (the mask, 1 = masked) is stored, and bits 31:1 always read 0. After reset every mask is 1 and every other table word is 0.
- R4: An application request (`app_req`=1 with `app_vec`=m) sets pending bit m at the next clock edge. The bit stays set until it is cleared.
- R5: A 64-bit read at `PBA_BASE`+8k returns pending bits 64k to 64k+63, with vector m at bit m mod 64.
- R6: A 32-bit read at `PBA_BASE`+4k returns pending bits 32k to 32k+31 in `host_rdata[31:0]`, with vector m at bit m mod 32.
- R7: Host writes to any offset at or above `PBA_BASE` change no pending bit.
- R8: `ip_clr`=1 clears the pending bit of vector `ip_vec` at the next clock edge.
- R9: A request and a clear for the same vector in the same cycle leave the bit set. A request and a clear for different vectors both take effect.
- R10: The lookup port is combinational. For `ip_vec` it drives the low address, high address, data, mask and pending bit of that vector.
- R11: Table offsets at or above 16·`NUM_VEC` read 0 and ignore writes. Pending bits at vector positions at or above `NUM_VEC`, and pending words past the array, read 0. Requests and lookups for vectors at or above `NUM_VEC` have no effect and return zeros.
- R12: `tbl_size_enc` equals `NUM_VEC`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_qw | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| host_addr | input | AW | Byte offset within the block window |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Host read data (combinational) |
| app_req | input | 1 | Application interrupt request |
| app_vec | input | VW | Vector number of the request |
| ip_vec | input | VW | Vector the interrupt processor looks up |
| ip_clr | input | 1 | Clear the pending bit of `ip_vec` |
| ip_addr_lo | output | 32 | Low message address of `ip_vec` |
| ip_addr_hi | output | 32 | High message address of `ip_vec` |
| ip_data | output | 32 | Message data of `ip_vec` |
| ip_masked | output | 1 | Mask bit of `ip_vec` |
| ip_pending | output | 1 | Pending bit of `ip_vec` |
| tbl_size_enc | output | 11 | Encoded table size (vector count minus one) |

## Verification
The default of 70 vectors makes the pending array span two 64-bit words, and its last 32-bit word is only partly used. Vectors 64 and 69 therefore show whether the qword and dword slicing is right and whether the padding reads as zero. A design that mixes up the two word sizes returns bits shifted by 32. The bench fires a request and a clear at one vector in the same cycle, which catches a design that lets the clear win and drops an interrupt. It also writes all ones into the pending array, which catches a design that lets the host set or clear pending bits. Writes past the last table slot and a request for vector 100 expose address decoding that aliases or wraps into real entries.

// File: rtl/msix_pkg.sv
package msix_pkg;
   localparam int MAX_VECTORS = 2048;

   typedef enum logic [1:0] {
      FLD_ADDR_LO = 2'd0,
      FLD_ADDR_HI = 2'd1,
      FLD_DATA    = 2'd2,
      FLD_CTRL    = 2'd3
   } msix_field_e;

   typedef struct packed {
      logic [31:0] addr_lo;
      logic [31:0] addr_hi;
      logic [31:0] data;
      logic        mask;
   } msix_entry_t;

   function automatic logic [31:0] ctrl_word(input logic mask);
      return {31'b0, mask};
   endfunction
endpackage

// File: rtl/msix_vec_table.sv
module msix_vec_table
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 70,
   parameter int AW      = 13,
   parameter int VW      = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic          acc_qw,
   input  logic [AW-1:0] addr,
   input  logic [63:0]   wdata,
   output logic [63:0]   rdata,
   input  logic [VW-1:0] ip_vec,
   output msix_entry_t   ip_entry
);
   localparam int IW = AW - 4;

   msix_entry_t ent_q [NUM_VEC];

   logic [IW-1:0] idx;
   logic [VW-1:0] sel;
   logic          in_rng;
   msix_field_e   fld;

   assign idx    = addr[AW-1:4];
   assign sel    = VW'(idx);
   assign in_rng = (int'(idx) < NUM_VEC);
   assign fld    = msix_field_e'(addr[3:2]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < NUM_VEC; e++)
            ent_q[e] <= '{addr_lo: '0, addr_hi: '0, data: '0, mask: 1'b1};
      end else if (wr_en && in_rng) begin
         if (acc_qw) begin
            if (!addr[3]) begin
               ent_q[sel].addr_lo <= wdata[31:0];
               ent_q[sel].addr_hi <= wdata[63:32];
            end else begin
               ent_q[sel].data <= wdata[31:0];
               ent_q[sel].mask <= wdata[32];
            end
         end else begin
            case (fld)
               FLD_ADDR_LO: ent_q[sel].addr_lo <= wdata[31:0];
               FLD_ADDR_HI: ent_q[sel].addr_hi <= wdata[31:0];
               FLD_DATA:    ent_q[sel].data    <= wdata[31:0];
               default:     ent_q[sel].mask    <= wdata[0];
            endcase
         end
      end
   end

   always_comb begin
      msix_entry_t r;
      r     = ent_q[sel];
      rdata = '0;
      if (in_rng) begin
         if (acc_qw) begin
            rdata = addr[3] ? {ctrl_word(r.mask), r.data} : {r.addr_hi, r.addr_lo};
         end else begin
            case (fld)
               FLD_ADDR_LO: rdata = {32'b0, r.addr_lo};
               FLD_ADDR_HI: rdata = {32'b0, r.addr_hi};
               FLD_DATA:    rdata = {32'b0, r.data};
               default:     rdata = {32'b0, ctrl_word(r.mask)};
            endcase
         end
      end
   end

   assign ip_entry = (int'(ip_vec) < NUM_VEC) ? ent_q[ip_vec] : '0;

   // R3
   mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_rng && !acc_qw && fld == FLD_CTRL)
      |=> ent_q[$past(sel)].mask == $past(wdata[0]));

   // R1
   lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_rng && !acc_qw && fld == FLD_ADDR_LO)
      |=> ent_q[$past(sel)].addr_lo == $past(wdata[31:0]));
endmodule

// File: rtl/msix_pend_array.sv
module msix_pend_array #(
   parameter int NUM_VEC = 70,
   parameter int VW      = 7,
   parameter int RIW     = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_en,
   input  logic [VW-1:0]      set_vec,
   input  logic               clr_en,
   input  logic [VW-1:0]      clr_vec,
   input  logic               rd_qw,
   input  logic [RIW-1:0]     rd_idx,
   output logic [63:0]        rdata,
   input  logic [VW-1:0]      ip_vec,
   output logic               ip_pend,
   output logic [NUM_VEC-1:0] pend_o
);
   localparam int NQ = (NUM_VEC + 63) / 64;
   localparam int ND = NQ * 2;
   localparam int PW = NQ * 64;

   logic [NUM_VEC-1:0] pend_q, set_hit, clr_hit;
   logic [PW-1:0]      pend_pad;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
      assign set_hit[v] = set_en && (set_vec == VW'(v));
      assign clr_hit[v] = clr_en && (clr_vec == VW'(v));

      // R4
      set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (set_en && set_vec == VW'(v)) |=> pend_q[v]);

      // R8
      clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en && clr_vec == VW'(v) && !(set_en && set_vec == VW'(v))) |=> !pend_q[v]);

      // R7
      no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!pend_q[v] && !(set_en && set_vec == VW'(v))) |=> !pend_q[v]);
   end

   // set has priority so a request is never lost (R9)
   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr_hit) | set_hit;
   end

   assign pend_pad = PW'(pend_q);
   assign pend_o   = pend_q;

   always_comb begin
      rdata = '0;
      if (rd_qw) begin
         if (int'(rd_idx) < NQ) rdata = pend_pad[int'(rd_idx)*64 +: 64];
      end else begin
         if (int'(rd_idx) < ND) rdata = {32'b0, pend_pad[int'(rd_idx)*32 +: 32]};
      end
   end

   assign ip_pend = (int'(ip_vec) < NUM_VEC) ? pend_q[ip_vec] : 1'b0;
endmodule

// File: rtl/msix_vector_store.sv
module msix_vector_store
   import msix_pkg::*;
#(
   parameter int NUM_VEC  = 70,
   parameter int PBA_BASE = 'h1000,
   parameter int AW       = 13,
   localparam int VW      = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_qw,
   input  logic [AW-1:0] host_addr,
   input  logic [63:0]   host_wdata,
   output logic [63:0]   host_rdata,
   input  logic          app_req,
   input  logic [VW-1:0] app_vec,
   input  logic [VW-1:0] ip_vec,
   input  logic          ip_clr,
   output logic [31:0]   ip_addr_lo,
   output logic [31:0]   ip_addr_hi,
   output logic [31:0]   ip_data,
   output logic          ip_masked,
   output logic          ip_pending,
   output logic [10:0]   tbl_size_enc
);
   localparam int NQ  = (NUM_VEC + 63) / 64;
   localparam int RIW = AW - 2;
   localparam logic [AW-1:0] PBA_OFS = AW'(PBA_BASE);

   if (NUM_VEC < 1 || NUM_VEC > MAX_VECTORS) begin : g_bad_count
      $error("vector count out of range");
   end
   if (PBA_BASE % 8 != 0 || PBA_BASE < 16 * NUM_VEC) begin : g_bad_base
      $error("pending array base misaligned or overlapping the table");
   end
   if (PBA_BASE + 8 * NQ > (1 << AW) || AW - 4 < VW) begin : g_bad_aw
      $error("address width too small");
   end

   logic               in_pba;
   logic [AW-1:0]      pba_rel;
   logic [RIW-1:0]     pba_idx;
   logic [63:0]        tbl_rdata, pba_rdata;
   msix_entry_t        ip_entry;
   logic [NUM_VEC-1:0] pend_vec;

   assign in_pba  = (host_addr >= PBA_OFS);
   assign pba_rel = host_addr - PBA_OFS;
   assign pba_idx = host_qw ? {1'b0, pba_rel[AW-1:3]} : pba_rel[AW-1:2];

   msix_vec_table #(.NUM_VEC(NUM_VEC), .AW(AW), .VW(VW)) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr && !in_pba),
      .acc_qw   (host_qw),
      .addr     (host_addr),
      .wdata    (host_wdata),
      .rdata    (tbl_rdata),
      .ip_vec   (ip_vec),
      .ip_entry (ip_entry)
   );

   msix_pend_array #(.NUM_VEC(NUM_VEC), .VW(VW), .RIW(RIW)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (app_req),
      .set_vec (app_vec),
      .clr_en  (ip_clr),
      .clr_vec (ip_vec),
      .rd_qw   (host_qw),
      .rd_idx  (pba_idx),
      .rdata   (pba_rdata),
      .ip_vec  (ip_vec),
      .ip_pend (ip_pending),
      .pend_o  (pend_vec)
   );

   assign host_rdata   = in_pba ? pba_rdata : tbl_rdata;
   assign ip_addr_lo   = ip_entry.addr_lo;
   assign ip_addr_hi   = ip_entry.addr_hi;
   assign ip_data      = ip_entry.data;
   assign ip_masked    = ip_entry.mask;
   assign tbl_size_enc = 11'(NUM_VEC - 1);

   // R7
   pba_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && in_pba && !app_req && !ip_clr) |=> $stable(pend_vec));
endmodule

// File: tb/msix_vector_store_bench.sv
module msix_vector_store_bench;
   typedef struct packed {
      logic        rd;
      logic        qw;
      logic [12:0] addr;
      logic [63:0] data;
   } step_t;

   localparam int NSTEP = 20;
   localparam step_t STEPS [NSTEP] = '{
      '{1'b0, 1'b0, 13'h000, 64'h0000_0000_AAAA_0000},   // R1
      '{1'b0, 1'b0, 13'h004, 64'h0000_0000_0000_0001},   // R1
      '{1'b0, 1'b0, 13'h008, 64'h0000_0000_0000_0055},   // R1
      '{1'b0, 1'b0, 13'h00C, 64'h0000_0000_FFFF_FFFE},   // R3
      '{1'b1, 1'b0, 13'h000, 64'h0000_0000_AAAA_0000},   // R1
      '{1'b1, 1'b0, 13'h004, 64'h0000_0000_0000_0001},   // R1
      '{1'b1, 1'b0, 13'h00C, 64'h0000_0000_0000_0000},   // R3
      '{1'b1, 1'b1, 13'h000, 64'h0000_0001_AAAA_0000},   // R2
      '{1'b1, 1'b1, 13'h008, 64'h0000_0000_0000_0055},   // R2
      '{1'b0, 1'b1, 13'h450, 64'h1234_5678_9ABC_DEF0},   // R2
      '{1'b1, 1'b0, 13'h454, 64'h0000_0000_1234_5678},   // R2
      '{1'b1, 1'b0, 13'h450, 64'h0000_0000_9ABC_DEF0},   // R2
      '{1'b0, 1'b1, 13'h45C, 64'h0000_0000_0000_00C3},   // R2 low bits ignored
      '{1'b1, 1'b0, 13'h45C, 64'h0000_0000_0000_0000},   // R2
      '{1'b1, 1'b0, 13'h05C, 64'h0000_0000_0000_0001},   // R3 reset mask
      '{1'b1, 1'b0, 13'h058, 64'h0000_0000_0000_0000},   // R3 reset data
      '{1'b0, 1'b0, 13'h460, 64'h0000_0000_DEAD_BEEF},   // R11
      '{1'b1, 1'b0, 13'h460, 64'h0000_0000_0000_0000},   // R11
      '{1'b0, 1'b0, 13'h0AC, 64'h0000_0000_0000_0003},   // R3
      '{1'b1, 1'b0, 13'h0AC, 64'h0000_0000_0000_0001}    // R3
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_qw = 1'b0;
   logic [12:0] host_addr = '0;
   logic [63:0] host_wdata = '0, host_rdata;
   logic        app_req = 1'b0, ip_clr = 1'b0;
   logic [6:0]  app_vec = '0, ip_vec = '0;
   logic [31:0] ip_addr_lo, ip_addr_hi, ip_data;
   logic        ip_masked, ip_pending;
   logic [10:0] tbl_size_enc;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   msix_vector_store u_msix_vector_store (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_qw(host_qw),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .app_req(app_req), .app_vec(app_vec), .ip_vec(ip_vec), .ip_clr(ip_clr),
      .ip_addr_lo(ip_addr_lo), .ip_addr_hi(ip_addr_hi), .ip_data(ip_data),
      .ip_masked(ip_masked), .ip_pending(ip_pending), .tbl_size_enc(tbl_size_enc)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic qw, input logic [12:0] a, input logic [63:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_qw = qw; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(input logic qw, input logic [12:0] a, output logic [63:0] d);
      @(negedge clk);
      host_qw = qw; host_addr = a;
      #1 d = host_rdata;
   endtask

   task automatic pulse(input logic req, input logic [6:0] av, input logic clr, input logic [6:0] cv);
      @(negedge clk);
      app_req = req; app_vec = av; ip_clr = clr; ip_vec = cv;
      @(negedge clk);
      app_req = 1'b0; ip_clr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      @(negedge clk); ip_vec = 7'd0; #1;
      check("R3 reset mask", {63'b0, ip_masked}, 64'd1);
      check("R3 reset addr", {32'b0, ip_addr_lo}, 64'd0);
      check("R4 reset pending", {63'b0, ip_pending}, 64'd0);
      check("R12 size field", {53'b0, tbl_size_enc}, 64'd69);
      hread(1'b1, 13'h1000, d); check("R5 reset pba", d, 64'd0);

      for (int i = 0; i < NSTEP; i++) begin
         if (STEPS[i].rd) begin
            hread(STEPS[i].qw, STEPS[i].addr, d);
            check($sformatf("R1/R2/R3/R11 table step %0d", i), d, STEPS[i].data);
         end else begin
            hwrite(STEPS[i].qw, STEPS[i].addr, STEPS[i].data);
         end
      end

      // R10 lookup port
      @(negedge clk); ip_vec = 7'd0; #1;
      check("R10 lo", {32'b0, ip_addr_lo}, 64'hAAAA0000);
      check("R10 hi", {32'b0, ip_addr_hi}, 64'h1);
      check("R10 data", {32'b0, ip_data}, 64'h55);
      check("R10 mask", {63'b0, ip_masked}, 64'd0);
      @(negedge clk); ip_vec = 7'd69; #1;
      check("R10 data v69", {32'b0, ip_data}, 64'hC3);

      // R4 requests
      pulse(1'b1, 7'd3, 1'b0, 7'd0);
      pulse(1'b1, 7'd40, 1'b0, 7'd0);
      pulse(1'b1, 7'd64, 1'b0, 7'd0);
      pulse(1'b1, 7'd69, 1'b0, 7'd0);
      hread(1'b1, 13'h1000, d); check("R4 R5 qword0", d, 64'h0000_0100_0000_0008);
      hread(1'b1, 13'h1008, d); check("R5 qword1", d, 64'h21);
      hread(1'b0, 13'h1000, d); check("R6 dword0", d, 64'h8);
      hread(1'b0, 13'h1004, d); check("R6 dword1", d, 64'h100);
      hread(1'b0, 13'h1008, d); check("R6 dword2", d, 64'h21);
      hread(1'b0, 13'h100C, d); check("R11 dword3 padding", d, 64'h0);
      @(negedge clk); ip_vec = 7'd40; #1;
      check("R10 pending", {63'b0, ip_pending}, 64'd1);

      // R7 host writes into the pending array
      hwrite(1'b1, 13'h1000, '1);
      hwrite(1'b0, 13'h1004, 64'h0);
      hread(1'b1, 13'h1000, d); check("R7 pba write ignored", d, 64'h0000_0100_0000_0008);

      // R8 clear
      pulse(1'b0, 7'd0, 1'b1, 7'd3);
      hread(1'b1, 13'h1000, d); check("R8 clear", d, 64'h0000_0100_0000_0000);

      // R9 set wins on same vector; different vectors both act
      pulse(1'b1, 7'd40, 1'b1, 7'd40);
      @(negedge clk); ip_vec = 7'd40; #1;
      check("R9 set wins", {63'b0, ip_pending}, 64'd1);
      pulse(1'b1, 7'd3, 1'b1, 7'd69);
      hread(1'b1, 13'h1008, d); check("R9 clear other", d, 64'h1);
      hread(1'b1, 13'h1000, d); check("R9 set other", d, 64'h0000_0100_0000_0008);

      // R11 out-of-range request and lookup
      pulse(1'b1, 7'd100, 1'b0, 7'd0);
      hread(1'b1, 13'h1008, d); check("R11 request ignored", d, 64'h1);
      hread(1'b1, 13'h1010, d); check("R11 past array", d, 64'h0);
      @(negedge clk); ip_vec = 7'd100; #1;
      check("R11 lookup pending", {63'b0, ip_pending}, 64'd0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule